// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block is a device-side model of the status that a parallel NOR flash returns when the host reads it while an internal program or erase operation is running. A one-cycle command strobe marks the end of a program or erase command sequence. It carries the operation type, the target address and byte, and a mask of sectors to erase. The block then runs a busy window whose length comes from a cycle-count input. During that window, reads return a polling status on bit 7 instead of array contents.

Erase can be suspended and resumed. While erase is suspended, a program operation may run. An attempt to program into a protected sector, or to erase when every selected sector is protected, runs a dummy busy window of fixed length (a parameter, in cycles) and changes no data. Array contents live in a small internal register file.

Reads use a valid/ready request channel and a valid/ready response channel with a single response register. A new request is accepted only when no response is held, or when the held response is taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `rd_ready` stays low. Command, suspend and resume pins are plain strobes.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, no operation is busy, `rsp_valid` is 0, `rd_ready` is 1, and every array byte reads 0xFF.
- R2: A read accepted at a clock edge (`rd_valid` and `rd_ready` both high) yields `rsp_valid`=1 with its data after that same edge. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` is held and `rd_ready` is 0.
- R3: A program command accepted at edge E0 keeps the program busy for N = `prog_cycles` edges (a value of 0 counts as 1). During those edges, a read at the program address returns bit 7 equal to the inverse of bit 7 of the programmed byte, with bits 6..0 equal to 0.
- R4: When programming completes, the stored byte becomes the old byte AND the new byte, and reads return it. Array bits never change from 0 to 1 except by erase.
- R5: The sector of an address is its top `SECT_W` bits. While erase runs (for `erase_cycles` edges, with 0 counting as 1), reads inside the erased sectors return 0x00. On completion, those sectors read 0xFF and other sectors are unchanged.
- R6: A suspend strobe during a running erase stops the erase count at that edge. While suspended, reads inside the erased sectors return 0x80. A resume strobe restarts the count with the remaining cycles.
- R7: A program command is accepted while erase is suspended and follows R3 and R4. An erase command is ignored while any operation is busy or suspended. A program and a running erase never overlap.
- R8: A program command whose address lies in a protected sector (`sect_prot` bit set) shows the R3 status for `PROG_PROT_CYC` edges, whatever `prog_cycles` is. It then leaves the array unchanged.
- R9: An erase command whose selected sectors are all protected shows 0x00 status for `ERASE_PROT_CYC` edges and changes nothing. If only some selected sectors are protected, only the unprotected ones are erased.
- R10: During a busy program or running erase, a read at an address with no valid status returns 0xFF. When nothing runs, or erase is suspended with no program running, reads outside the status addresses return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle strobe: final write of a program or erase command |
| op_erase | input | 1 | 1 = erase, 0 = program (sampled with `op_start`) |
| op_addr | input | ADDR_W | Program address |
| op_data | input | DATA_W | Byte to program |
| op_sectors | input | 2**SECT_W | Sectors selected for erase |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| prog_cycles | input | CNT_W | Normal program duration in cycles |
| erase_cycles | input | CNT_W | Normal erase duration in cycles |
| susp_req | input | 1 | Erase-suspend strobe |
| resume_req | input | 1 | Erase-resume strobe |
| rd_valid | input | 1 | Read request valid |
| rd_addr | input | ADDR_W | Read address |
| rd_ready | output | 1 | Read request accepted when high |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed when high |
| rsp_data | output | DATA_W | Read response: status or array byte |

## Verification
A command strobe sampled at edge E0 makes the status due on reads sampled at E1 through EN, and array data due from E(N+1). A suspend or resume strobe takes effect at the edge that samples it, and that edge does not count toward the erase. Every read response is due one edge after the request is accepted. The bench therefore drives each input at a falling edge and samples the response at the next falling edge. It walks the status window read by read, so that the last status read and the first data read are both checked at their exact edges.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [2:0] {
    SRC_ARRAY,
    SRC_PROG,
    SRC_ERASE_RUN,
    SRC_ERASE_SUSP,
    SRC_INVALID
  } rd_src_e;
endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = en && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= (load_val == '0) ? CNT_W'(1) : load_val;
    else if (en && busy)
      cnt <= cnt - CNT_W'(1);
  end

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en && !load) |=> $stable(cnt));
endmodule

// File: rtl/fws_array.sv
module fws_array #(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_we,
  input  logic [ADDR_W-1:0]      prog_addr,
  input  logic [DATA_W-1:0]      prog_data,
  input  logic                   erase_we,
  input  logic [(1<<SECT_W)-1:0] erase_mask,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SEC_LSB = ADDR_W - SECT_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam int SEC = i >> SEC_LSB;
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '1;
      else if (erase_we && erase_mask[SEC])
        mem[i] <= '1;
      else if (prog_we && prog_addr == ADDR_W'(i))
        mem[i] <= mem[i] & prog_data;
    end

    // R4
    bits_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_we && erase_mask[SEC]) |=> ((mem[i] & ~$past(mem[i])) == '0));
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fws_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int SECT_W         = 2,
  parameter int DATA_W         = 8,
  parameter int CNT_W          = 16,
  parameter int PROG_PROT_CYC  = 6,
  parameter int ERASE_PROT_CYC = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_start,
  input  logic                   op_erase,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic [DATA_W-1:0]      op_data,
  input  logic [(1<<SECT_W)-1:0] op_sectors,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  input  logic [CNT_W-1:0]       prog_cycles,
  input  logic [CNT_W-1:0]       erase_cycles,
  input  logic                   susp_req,
  input  logic                   resume_req,
  input  logic                   rd_valid,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_ready,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_data
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [DATA_W-1:0] MSB_ONLY = DATA_W'(1) << (DATA_W - 1);

  // operation state
  logic              pbusy, pdone, ebusy, edone, susp_q, erun;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic              p_dummy, e_dummy;
  logic [NSECT-1:0]  e_mask, e_eff;
  logic              prog_start, erase_start, resume_ok, p_prot;
  logic [CNT_W-1:0]  p_len, e_len;

  assign erun        = ebusy && !susp_q;
  assign prog_start  = op_start && !op_erase && !pbusy && !erun;
  assign erase_start = op_start && op_erase && !pbusy && !ebusy;
  assign resume_ok   = susp_q && resume_req && !pbusy && !prog_start;
  assign p_prot      = sect_prot[op_addr[ADDR_W-1 -: SECT_W]];
  assign e_eff       = op_sectors & ~sect_prot;
  assign p_len       = p_prot ? CNT_W'(PROG_PROT_CYC) : prog_cycles;
  assign e_len       = (e_eff == '0) ? CNT_W'(ERASE_PROT_CYC) : erase_cycles;

  fws_timer #(.CNT_W(CNT_W)) u_ptimer (
    .clk(clk), .rst_n(rst_n), .load(prog_start), .load_val(p_len),
    .en(1'b1), .busy(pbusy), .done(pdone)
  );

  fws_timer #(.CNT_W(CNT_W)) u_etimer (
    .clk(clk), .rst_n(rst_n), .load(erase_start), .load_val(e_len),
    .en(erun && !susp_req), .busy(ebusy), .done(edone)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_addr  <= '0;
      p_data  <= '0;
      p_dummy <= 1'b0;
      e_mask  <= '0;
      e_dummy <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      if (prog_start) begin
        p_addr  <= op_addr;
        p_data  <= op_data;
        p_dummy <= p_prot;
      end
      if (erase_start) begin
        e_dummy <= (e_eff == '0);
        e_mask  <= (e_eff == '0) ? op_sectors : e_eff;
      end
      if (resume_ok)
        susp_q <= 1'b0;
      else if (erun && susp_req)
        susp_q <= 1'b1;
    end
  end

  // array
  logic [DATA_W-1:0] arr_data;

  fws_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .prog_we(pdone && !p_dummy), .prog_addr(p_addr), .prog_data(p_data),
    .erase_we(edone && !e_dummy), .erase_mask(e_mask),
    .rd_addr(rd_addr), .rd_data(arr_data)
  );

  // read source selection
  rd_src_e           src;
  logic [DATA_W-1:0] rd_byte;

  always_comb begin
    if (pbusy && rd_addr == p_addr)
      src = SRC_PROG;
    else if (ebusy && e_mask[rd_addr[ADDR_W-1 -: SECT_W]])
      src = susp_q ? SRC_ERASE_SUSP : SRC_ERASE_RUN;
    else if (pbusy || erun)
      src = SRC_INVALID;
    else
      src = SRC_ARRAY;

    case (src)
      SRC_PROG:       rd_byte = p_data[DATA_W-1] ? '0 : MSB_ONLY;
      SRC_ERASE_RUN:  rd_byte = '0;
      SRC_ERASE_SUSP: rd_byte = MSB_ONLY;
      SRC_INVALID:    rd_byte = '1;
      default:        rd_byte = arr_data;
    endcase
  end

  // response register
  logic accept;
  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R2
  rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pbusy && erun));
  // R3
  prog_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pbusy) |-> $past(op_start && !op_erase));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0, op_erase = 1'b0;
  logic [3:0] op_addr = '0;
  logic [7:0] op_data = '0;
  logic [3:0] op_sectors = '0, sect_prot = '0;
  logic [15:0] prog_cycles = 16'd3, erase_cycles = 16'd4;
  logic       susp_req = 1'b0, resume_req = 1'b0;
  logic       rd_valid = 1'b0;
  logic [3:0] rd_addr = '0;
  logic       rd_ready, rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.PROG_PROT_CYC(6), .ERASE_PROT_CYC(9)) dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .op_sectors(op_sectors),
    .sect_prot(sect_prot), .prog_cycles(prog_cycles), .erase_cycles(erase_cycles),
    .susp_req(susp_req), .resume_req(resume_req), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // program table: address, byte, expected stored byte afterwards
  localparam logic [19:0] PVEC [4] = '{
    {4'd1,  8'h5A, 8'h5A},
    {4'd1,  8'h0F, 8'h0A},
    {4'd6,  8'hC3, 8'hC3},
    {4'd15, 8'h80, 8'h80}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    rd_valid = 1'b1;
    rd_addr  = a;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check({tag, " valid"}, {7'd0, rsp_valid}, 8'd1);
    check(tag, rsp_data, exp);
  endtask

  task automatic start_prog(input logic [3:0] a, input logic [7:0] d);
    op_start = 1'b1; op_erase = 1'b0; op_addr = a; op_data = d;
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic start_erase(input logic [3:0] m);
    op_start = 1'b1; op_erase = 1'b1; op_sectors = m;
    @(posedge clk);
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    check("R1 rd_ready", {7'd0, rd_ready}, 8'd1);
    rd(4'd0, 8'hFF, "R1 array erased");

    // R3 R4 R10 table of program operations, prog_cycles = 3
    prog_cycles = 16'd3;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] a;
      logic [7:0] d, fin, st;
      {a, d, fin} = PVEC[i];
      st = d[7] ? 8'h00 : 8'h80;
      start_prog(a, d);
      rd(a, st, "R3 status edge1");
      rd(a ^ 4'h8, 8'hFF, "R10 invalid addr");
      rd(a, st, "R3 status last edge");
      rd(a, fin, "R4 programmed byte");
    end

    // R5 erase sector 0, 4 cycles
    erase_cycles = 16'd4;
    start_erase(4'b0001);
    rd(4'd0, 8'h00, "R5 erase status");
    rd(4'd9, 8'hFF, "R10 invalid during erase");
    rd(4'd1, 8'h00, "R5 erase status");
    rd(4'd1, 8'h00, "R5 erase last edge");
    rd(4'd1, 8'hFF, "R5 erased byte");
    rd(4'd6, 8'hC3, "R5 other sector kept");

    // R6 R7 suspend / program in suspend / resume
    erase_cycles = 16'd6;
    start_erase(4'b0010);
    rd(4'd4, 8'h00, "R6 running erase");
    susp_req = 1'b1; @(posedge clk); @(negedge clk); susp_req = 1'b0;
    rd(4'd5, 8'h80, "R6 suspended status");
    rd(4'd15, 8'h80, "R10 array read while suspended");
    idle(4);
    start_erase(4'b0100);  // must be ignored
    prog_cycles = 16'd2;
    start_prog(4'd10, 8'h3C);
    rd(4'd10, 8'h80, "R7 program in suspend");
    rd(4'd4, 8'h80, "R7 erase sector during suspend program");
    rd(4'd10, 8'h3C, "R7 programmed in suspend");
    resume_req = 1'b1; @(posedge clk); @(negedge clk); resume_req = 1'b0;
    for (int k = 0; k < 5; k++) rd(4'd6, 8'h00, "R6 remaining erase");
    rd(4'd6, 8'hFF, "R6 erase done after resume");
    rd(4'd10, 8'h3C, "R7 ignored erase left sector 2");

    // R3 zero count means one cycle
    prog_cycles = 16'd0;
    start_prog(4'd0, 8'h7F);
    rd(4'd0, 8'h80, "R3 zero count status");
    rd(4'd0, 8'h7F, "R3 zero count done");

    // R8 protected program
    sect_prot = 4'b1000;
    prog_cycles = 16'd2;
    start_prog(4'd13, 8'h00);
    for (int k = 0; k < 6; k++) rd(4'd13, 8'h80, "R8 protected window");
    rd(4'd13, 8'hFF, "R8 data unchanged");

    // R9 all-protected erase
    erase_cycles = 16'd2;
    start_erase(4'b1000);
    for (int k = 0; k < 9; k++) rd(4'd12, 8'h00, "R9 protected erase window");
    rd(4'd12, 8'hFF, "R9 back to array");
    rd(4'd15, 8'h80, "R9 data unchanged");

    // R9 partial protection
    sect_prot = 4'b0000;
    prog_cycles = 16'd1;
    start_prog(4'd12, 8'h22);
    rd(4'd12, 8'h80, "R3 status");
    rd(4'd12, 8'h22, "R4 byte");
    start_prog(4'd9, 8'h44);
    rd(4'd9, 8'h80, "R3 status");
    rd(4'd9, 8'h44, "R4 byte");
    sect_prot = 4'b1000;
    start_erase(4'b1100);
    rd(4'd9, 8'h00, "R9 partial status");
    rd(4'd9, 8'h00, "R9 partial last edge");
    rd(4'd9, 8'hFF, "R9 unprotected erased");
    rd(4'd10, 8'hFF, "R9 unprotected erased");
    rd(4'd12, 8'h22, "R9 protected kept");

    // R2 back-pressure
    rsp_ready = 1'b0;
    rd_valid = 1'b1; rd_addr = 4'd12;
    @(posedge clk); @(negedge clk);
    rd_addr = 4'd0;
    check("R2 rsp_valid", {7'd0, rsp_valid}, 8'd1);
    check("R2 rsp_data", rsp_data, 8'h22);
    check("R2 rd_ready low", {7'd0, rd_ready}, 8'd0);
    @(posedge clk); @(negedge clk);
    check("R2 held data", rsp_data, 8'h22);
    check("R2 held valid", {7'd0, rsp_valid}, 8'd1);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    check("R2 next response", rsp_data, 8'h7F);
    @(posedge clk); @(negedge clk);
    check("R2 drained", {7'd0, rsp_valid}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule